// File: doc/BRIEF.md
# Serial Line Automatic Baud-Rate Detector

This block finds the bit rate of an asynchronous 8N1 receive line. While it detects, a host sends the byte 0x00 over and over. Each such byte reaches the line as one unbroken low stretch: the start bit and eight zero data bits, nine bit times in all. That stretch is followed by at least one high bit time. The block counts the system clocks of one such low stretch. It divides the count by nine, rounding to nearest, with a small sequential divider. The result is a clocks-per-bit divisor, which it drives as an output.

With the new divisor, the block sends one 0x00 byte on its transmit line to show that adjustment is done. It then waits for a single confirmation byte from the host. This byte is sampled at mid-bit with the same divisor. If it reads 0x55 with a high stop bit, the block raises `locked`. Any other value, or a low stop bit, raises `error`. Both outcomes are final until reset, so a failed confirmation means starting detection again from reset.

Before any edge detection, the receive input passes through a two-flop synchronizer and a glitch filter. Some low stretches cannot be real bytes: one shorter than a minimum plausible length, or one that runs the counter past its ceiling. Such a stretch is thrown away, and detection starts again on the next falling edge.

Top module: `autobaud_sync`

## Requirements
- R1: During and after reset, `tx` is high, `baud_div` is 0, and `locked` and `error` are both 0.
- R2: The divisor is derived from the number L of consecutive clocks the line stays low: `baud_div` = floor((L + 4) / 9), which is L/9 rounded to nearest with a half rounded up.
- R3: A low stretch with L below `MIN_LOW` is discarded. `baud_div` stays 0, nothing is transmitted, and the next low stretch is measured afresh.
- R4: A low stretch with L = 2^`CNT_W` - 1 is accepted. One that lasts longer is discarded like R3, and detection re-arms on the next falling edge.
- R5: Once the divisor is known, `tx` sends exactly one 0x00 byte: it is low for exactly 9 x `baud_div` clocks, then returns high. `tx` is never low while `baud_div` is 0.
- R6: After the acknowledgment, an 8N1 byte 0x55 (bits sent LSB first, each lasting `baud_div` clocks, stop bit high) sets `locked` to 1 and leaves `error` at 0.
- R7: A confirmation byte with any value other than 0x55 sets `error` to 1 and leaves `locked` at 0.
- R8: A confirmation byte 0x55 whose stop bit is low sets `error` to 1 and leaves `locked` at 0.
- R9: `locked` and `error` never both read 1. Once one of them is set, it holds until reset. Later activity on `rx` leaves `baud_div` unchanged and causes no transmission.
- R10: Pulses on `rx` that last fewer than `GLITCH` clocks are ignored. A 2-clock high spike inside a low stretch does not split it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Asynchronous serial receive line, idle high |
| tx | output | 1 | Serial transmit line carrying the acknowledgment byte |
| baud_div | output | CNT_W-2 | Derived clocks-per-bit divisor, 0 until measured |
| locked | output | 1 | Confirmation byte received correctly |
| error | output | 1 | Confirmation byte wrong or framed badly |

## Verification
Two decisions can land in the same cycle: the measured low stretch ending on a rising edge, and the length counter reaching its ceiling. To provoke this, the bench builds the block with a 10-bit counter. It drives low stretches of exactly 1023 and 1024 clocks. The first must yield a divisor of 114 followed by a full handshake. The second must leave the divisor at 0 and `tx` idle, and the next normal 144-clock stretch must then be measured as 16.

// File: rtl/abd_pkg.sv
package abd_pkg;

    localparam int BIT_TIMES   = 9;
    localparam int ROUND_BIAS  = 4;
    localparam logic [7:0] CONFIRM_BYTE = 8'h55;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_MEAS,
        ST_DIV,
        ST_ACK_GO,
        ST_ACK,
        ST_CWAIT,
        ST_CRX,
        ST_LOCK,
        ST_FAIL
    } abd_state_e;

    typedef struct packed {
        logic       q;
        logic [3:0] rem;
    } div_step_t;

    // one restoring-division step by nine
    function automatic div_step_t div9_step(input logic [3:0] rem_in, input logic nxt);
        logic [4:0] trial;
        div_step_t  r;
        trial = {rem_in, nxt};
        if (trial >= 5'(BIT_TIMES)) begin
            r.q   = 1'b1;
            r.rem = 4'(trial - 5'(BIT_TIMES));
        end else begin
            r.q   = 1'b0;
            r.rem = trial[3:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/abd_rx_filter.sv
module abd_rx_filter #(
    parameter int GLITCH = 3,
    localparam int GW = $clog2(GLITCH) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    output logic rx_clean
);
    logic [1:0]    sync_q;
    logic [GW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= 2'b00;
            run_q    <= '0;
            rx_clean <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rx_raw};
            if (sync_q[1] != rx_clean) begin
                if (run_q == GW'(GLITCH - 1)) begin
                    rx_clean <= sync_q[1];
                    run_q    <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/abd_div9.sv
module abd_div9
    import abd_pkg::*;
#(
    parameter int DVD_W = 21,
    parameter int QW    = 18,
    localparam int IW   = $clog2(DVD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    output logic             done,
    output logic [QW-1:0]    quot
);
    logic [DVD_W-1:0] dvd_q;
    logic [3:0]       rem_q;
    logic [IW-1:0]    left_q;
    logic             busy_q;
    div_step_t        step;

    always_comb step = div9_step(rem_q, dvd_q[DVD_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            rem_q  <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
            quot   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvd_q  <= dividend;
                rem_q  <= '0;
                quot   <= '0;
                left_q <= IW'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                dvd_q  <= dvd_q << 1;
                rem_q  <= step.rem;
                quot   <= {quot[QW-2:0], step.q};
                left_q <= left_q - 1'b1;
                if (left_q == IW'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/abd_ack_tx.sv
module abd_ack_tx #(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    output logic             done,
    output logic             tx
);
    logic [3:0]       bit_q;
    logic [DIV_W-1:0] tick_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= '0;
            tick_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
            tx     <= 1'b1;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                bit_q  <= '0;
                tick_q <= DIV_W'(1);
                tx     <= 1'b0;
            end else if (busy_q) begin
                if (tick_q == div) begin
                    tick_q <= DIV_W'(1);
                    if (bit_q == 4'd9) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        tx    <= (bit_q >= 4'd8);
                    end
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/autobaud_sync.sv
module autobaud_sync
    import abd_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int MIN_LOW = 36,
    parameter int GLITCH  = 3,
    localparam int DIV_W  = CNT_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx,
    output logic             tx,
    output logic [DIV_W-1:0] baud_div,
    output logic             locked,
    output logic             error
);
    localparam int DVD_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_LOW);

    abd_state_e       state;
    logic             rxf, rxf_prev, fall;
    logic [CNT_W-1:0] meas_cnt;
    logic [DIV_W-1:0] t_q, target;
    logic [3:0]       bidx;
    logic [7:0]       sh;
    logic             div_start, div_done, ack_done;
    logic [DIV_W-1:0] quot;

    abd_rx_filter #(.GLITCH(GLITCH)) filt_i (
        .clk(clk), .rst(rst), .rx_raw(rx), .rx_clean(rxf)
    );

    assign div_start = (state == ST_MEAS) && rxf && (meas_cnt >= MIN_C);

    abd_div9 #(.DVD_W(DVD_W), .QW(DIV_W)) div_i (
        .clk(clk), .rst(rst), .start(div_start),
        .dividend({1'b0, meas_cnt} + DVD_W'(ROUND_BIAS)),
        .done(div_done), .quot(quot)
    );

    abd_ack_tx #(.DIV_W(DIV_W)) ack_i (
        .clk(clk), .rst(rst), .start(state == ST_ACK_GO),
        .div(baud_div), .done(ack_done), .tx(tx)
    );

    assign fall   = rxf_prev & ~rxf;
    assign target = (bidx == 4'd0) ? (baud_div >> 1) : baud_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            rxf_prev <= 1'b0;
            meas_cnt <= '0;
            baud_div <= '0;
            locked   <= 1'b0;
            error    <= 1'b0;
            t_q      <= '0;
            bidx     <= '0;
            sh       <= '0;
        end else begin
            rxf_prev <= rxf;
            case (state)
                ST_HUNT: if (fall) begin
                    meas_cnt <= CNT_W'(1);
                    state    <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (!rxf) begin
                        if (meas_cnt == CNT_MAX) state <= ST_HUNT;
                        else meas_cnt <= meas_cnt + 1'b1;
                    end else if (meas_cnt < MIN_C) begin
                        state <= ST_HUNT;
                    end else begin
                        state <= ST_DIV;
                    end
                end
                ST_DIV: if (div_done) begin
                    baud_div <= quot;
                    state    <= ST_ACK_GO;
                end
                ST_ACK_GO: state <= ST_ACK;
                ST_ACK:    if (ack_done) state <= ST_CWAIT;
                ST_CWAIT: if (fall) begin
                    t_q   <= DIV_W'(1);
                    bidx  <= '0;
                    state <= ST_CRX;
                end
                ST_CRX: begin
                    if (t_q == target) begin
                        t_q  <= DIV_W'(1);
                        bidx <= bidx + 1'b1;
                        if (bidx == 4'd0) begin
                            if (rxf) state <= ST_CWAIT;
                        end else if (bidx <= 4'd8) begin
                            sh <= {rxf, sh[7:1]};
                        end else if (rxf && sh == CONFIRM_BYTE) begin
                            locked <= 1'b1;
                            state  <= ST_LOCK;
                        end else begin
                            error <= 1'b1;
                            state <= ST_FAIL;
                        end
                    end else begin
                        t_q <= t_q + 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/autobaud_sync_chk.sv
module autobaud_sync_chk #(
    parameter int CNT_W   = 20,
    parameter int MIN_LOW = 36,
    localparam int DIV_W  = CNT_W - 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tx,
    input logic [DIV_W-1:0] baud_div,
    input logic             locked,
    input logic             error
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'((MIN_LOW + 4) / 9);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx && baud_div == '0 && !locked && !error));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(locked && error));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    a_r2_div_held: assert property (@(posedge clk) disable iff (rst)
        (baud_div != '0) |=> $stable(baud_div));

    a_r5_quiet_before_div: assert property (@(posedge clk) disable iff (rst)
        (baud_div == '0) |-> tx);

    a_r3_div_floor: assert property (@(posedge clk) disable iff (rst)
        (baud_div != '0) |-> (baud_div >= MIN_DIV));

    a_r6_idle_at_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> tx);
endmodule

bind autobaud_sync autobaud_sync_chk #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) chk_i (.*);

// File: tb/autobaud_sync_tb.sv
module autobaud_sync_tb_top;
    localparam int CNT_W = 10;
    localparam int DIV_W = CNT_W - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b1;
    logic tx, locked, error;
    logic [DIV_W-1:0] baud_div;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    autobaud_sync #(.CNT_W(CNT_W), .MIN_LOW(36), .GLITCH(3)) dut_i (
        .clk(clk), .rst(rst), .rx(rx), .tx(tx),
        .baud_div(baud_div), .locked(locked), .error(error)
    );

    typedef struct packed {
        int         len;
        int         dv;
        logic [7:0] conf;
        logic       stop;
        logic       lk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{144,  16, 8'h55, 1'b1, 1'b1},   // R2 R6 nominal
        '{148,  16, 8'h55, 1'b1, 1'b1},   // R2 rounds down
        '{149,  17, 8'h55, 1'b1, 1'b1},   // R2 rounds up
        '{40,    4, 8'h55, 1'b1, 1'b1},   // R3 near the minimum
        '{1023, 114, 8'h55, 1'b1, 1'b1},  // R4 counter ceiling accepted
        '{144,  16, 8'h54, 1'b1, 1'b0},   // R7 wrong value
        '{139,  15, 8'hAA, 1'b1, 1'b0},   // R7 inverted pattern
        '{144,  16, 8'h55, 1'b0, 1'b0}    // R8 low stop bit
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx  = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic drive_low(input int n);
        rx = 1'b0;
        repeat (n) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop, input int dv);
        for (int i = 0; i < 10; i++) begin
            rx = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
            repeat (dv) @(negedge clk);
        end
        rx = 1'b1;
    endtask

    // returns the number of clocks tx stays low, 0 if it never falls
    task automatic measure_ack(output int n);
        int waited = 0;
        n = 0;
        while (tx && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        while (!tx && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_tx_low(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!tx) n++;
        end
    endtask

    initial begin
        #(8 * 190000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int n;

        // R1 reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tx", tx, 1);
        check("R1 div", baud_div, 0);
        check("R1 locked", locked, 0);
        check("R1 error", error, 0);

        foreach (VECS[k]) begin
            do_reset();
            drive_low(VECS[k].len);
            measure_ack(n);
            check("R2 divisor", baud_div, VECS[k].dv);
            check("R5 ack low length", n, 9 * VECS[k].dv);
            repeat (2 * VECS[k].dv) @(negedge clk);
            send_byte(VECS[k].conf, VECS[k].stop, VECS[k].dv);
            repeat (VECS[k].dv) @(negedge clk);
            if (VECS[k].lk) check("R6 locked", locked, 1);
            else if (VECS[k].stop) check("R7 error", error, 1);
            else check("R8 error", error, 1);
            check("R9 flags differ", locked + error, 1);
        end

        // R9: activity after lock is ignored
        do_reset();
        drive_low(144);
        measure_ack(n);
        repeat (32) @(negedge clk);
        send_byte(8'h55, 1'b1, 16);
        repeat (16) @(negedge clk);
        drive_low(200);
        count_tx_low(300, n);
        check("R9 no tx after lock", n, 0);
        send_byte(8'h00, 1'b1, 16);
        repeat (16) @(negedge clk);
        check("R9 div held", baud_div, 16);
        check("R9 lock held", locked, 1);
        check("R9 error clear", error, 0);

        // R3: too-short low discarded, next one measured
        do_reset();
        drive_low(35);
        count_tx_low(300, n);
        check("R3 no ack", n, 0);
        check("R3 div zero", baud_div, 0);
        drive_low(144);
        measure_ack(n);
        check("R3 rearm div", baud_div, 16);

        // R4: one past the counter ceiling is discarded
        do_reset();
        drive_low(1024);
        count_tx_low(300, n);
        check("R4 no ack", n, 0);
        check("R4 div zero", baud_div, 0);
        drive_low(144);
        measure_ack(n);
        check("R4 rearm div", baud_div, 16);
        check("R4 rearm ack", n, 144);

        // R10: short high spike inside a low stretch
        do_reset();
        drive_low(100);
        repeat (2) @(negedge clk);
        drive_low(48);
        measure_ack(n);
        check("R10 spike ignored", baud_div, 17);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule